// File: doc/BRIEF.md
# Thermal Sigma-Delta Phase Sequencer

This block is the digital timing core of a first-order thermal sigma-delta readout. It runs the modulator one period at a time. Each period is split into three phases that always come in the same order. First comes a two-step correlated-double-sampling read. In its first step the bridge bias is reversed and the track/hold follows the amplifier. In its second step the held value is kept, the bias is flipped back to nominal, and the comparator is strobed. Next comes a return-to-zero feedback pulse, in which the comparator decision removes the bias from one half of a split detector bridge. Last comes a padding delay that fills the rest of the period at nominal bias. The length of the padding delay sets the duty ratio of the feedback.

Every phase length is a count of fast system-clock cycles and comes from a set of length inputs. The block takes a new set of lengths only when a period starts. At that point it also flags whether the lengths fail to add up to the requested period. The comparator decision of each period leaves the block as a one-bit stream, together with a one-cycle qualifying clock pulse.

Top module: `tsd_phase_seq`

## Requirements
- R1: While and straight after reset, the bridge sits at nominal bias (biasCom=0, biasF1=1, biasF2=1) with thTrack=1. bitOut, bitClk, cmpStrobe and cfgError are all 0.
- R2: A period opens with the reversed-bias track step (biasCom=1, biasF1=0, biasF2=0, thTrack=1), lasting trackLen cycles. The steps then follow in the fixed order track, flip, feedback, padding, and the next period opens with a track step again.
- R3: The flip step drives biasCom=0, biasF1=1, biasF2=1 and thTrack=0 for flipLen cycles. cmpStrobe is 1 only in the last cycle of the flip step.
- R4: In the cycle after cmpStrobe, bitOut equals the cmpDecision value present during the strobe cycle, and bitClk is 1. bitClk is 1 in no other cycle, and bitOut changes only together with a bitClk pulse.
- R5: The feedback step lasts fbLen cycles with biasCom=0 and thTrack=1. A decision of 1 cuts the first half (biasF1=0, biasF2=1) and a decision of 0 cuts the second half (biasF1=1, biasF2=0). Both halves are never cut at once. When fbLen is 0, the step is skipped.
- R6: The padding step restores nominal bias with thTrack=1 for padLen cycles. When padLen is 0, the step is skipped. The period then lasts exactly the sum of its step lengths.
- R7: cfgError is updated only as a period opens. It is 1 exactly when trackLen+flipLen+fbLen+padLen differs from periodLen, or when trackLen or flipLen is 0.
- R8: A trackLen or flipLen of 0 runs that step for one cycle.
- R9: The length inputs are captured when a period opens. A change during a period affects only the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trackLen | input | CNT_W | Cycles of the reversed-bias track step |
| flipLen | input | CNT_W | Cycles of the flip-and-compare step |
| fbLen | input | CNT_W | Cycles of the feedback pulse |
| padLen | input | CNT_W | Cycles of the padding delay |
| periodLen | input | CNT_W | Expected total period in cycles |
| cmpDecision | input | 1 | Comparator output, 1 meaning the second reading is above the held one |
| biasCom | output | 1 | Common bridge-bias line |
| biasF1 | output | 1 | Bias line of the first bridge half |
| biasF2 | output | 1 | Bias line of the second bridge half |
| thTrack | output | 1 | Track/hold control, 1 = track, 0 = hold |
| cmpStrobe | output | 1 | Comparator sampling strobe |
| bitOut | output | 1 | Bitstream data |
| bitClk | output | 1 | One-cycle pulse marking a new bitstream bit |
| cfgError | output | 1 | Period lengths inconsistent |

## Verification
The assertions assume that cmpDecision is settled during the strobe cycle. They also assume that a configuration only reaches the sequencer at a period boundary, so that the flags and bias patterns are checked against the latched lengths and not against the live inputs. The stimulus holds cmpDecision constant for a whole period and changes it only in the first track cycle. It changes length inputs only right after a falling clock edge, and it keeps every length well below the counter width, so the sum never wraps.

// File: rtl/tsd_seq_pkg.sv
package tsd_seq_pkg;

  typedef enum logic [1:0] {
    PH_TRACK    = 2'd0,
    PH_FLIP     = 2'd1,
    PH_FEEDBACK = 2'd2,
    PH_PAD      = 2'd3
  } phase_e;

  // strobes from the control FSM to the bias/bit datapath
  typedef struct packed {
    phase_e phase;
    logic   sampleNow;
  } seqStrobes_t;

endpackage

// File: rtl/tsd_seq_ctrl.sv
module tsd_seq_ctrl
  import tsd_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] trackLen,
  input  logic [CNT_W-1:0] flipLen,
  input  logic [CNT_W-1:0] fbLen,
  input  logic [CNT_W-1:0] padLen,
  input  logic [CNT_W-1:0] periodLen,
  output seqStrobes_t      strobes,
  output logic             cfgError
);

  localparam int SUM_W = CNT_W + 2;

  phase_e           phase, nxtPhase;
  logic [CNT_W-1:0] remain, nxtRemain;
  logic [CNT_W-1:0] shFlip, shFb, shPad;
  logic             lastCycle;
  logic             startPeriod;
  logic [SUM_W-1:0] sumLen;
  logic             cfgBad;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign lastCycle = (remain == CNT_W'(1));

  // R7: consistency of the set captured at the period boundary
  assign sumLen = SUM_W'(trackLen) + SUM_W'(flipLen) + SUM_W'(fbLen) + SUM_W'(padLen);
  assign cfgBad = (sumLen != SUM_W'(periodLen)) || (trackLen == '0) || (flipLen == '0);

  always_comb begin
    nxtPhase    = phase;
    nxtRemain   = remain - CNT_W'(1);
    startPeriod = 1'b0;
    if (lastCycle) begin
      unique case (phase)
        PH_TRACK: begin
          nxtPhase  = PH_FLIP;
          nxtRemain = atLeastOne(shFlip);
        end
        PH_FLIP: begin
          if (shFb != '0) begin
            nxtPhase  = PH_FEEDBACK;
            nxtRemain = shFb;
          end else if (shPad != '0) begin
            nxtPhase  = PH_PAD;
            nxtRemain = shPad;
          end else begin
            startPeriod = 1'b1;
          end
        end
        PH_FEEDBACK: begin
          if (shPad != '0) begin
            nxtPhase  = PH_PAD;
            nxtRemain = shPad;
          end else begin
            startPeriod = 1'b1;
          end
        end
        default: startPeriod = 1'b1;
      endcase
    end
    if (startPeriod) begin
      nxtPhase  = PH_TRACK;
      nxtRemain = atLeastOne(trackLen);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_PAD;
      remain   <= CNT_W'(1);
      shFlip   <= '0;
      shFb     <= '0;
      shPad    <= '0;
      cfgError <= 1'b0;
    end else begin
      phase  <= nxtPhase;
      remain <= nxtRemain;
      if (startPeriod) begin
        shFlip   <= flipLen;
        shFb     <= fbLen;
        shPad    <= padLen;
        cfgError <= cfgBad;
      end
    end
  end

  assign strobes.phase     = phase;
  assign strobes.sampleNow = (phase == PH_FLIP) && lastCycle;

endmodule

// File: rtl/tsd_seq_dp.sv
module tsd_seq_dp
  import tsd_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  input  logic        cmpDecision,
  output logic        biasCom,
  output logic        biasF1,
  output logic        biasF2,
  output logic        thTrack,
  output logic        cmpStrobe,
  output logic        bitOut,
  output logic        bitClk
);

  // bitOut doubles as the stored decision steering the feedback step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitOut <= 1'b0;
      bitClk <= 1'b0;
    end else begin
      bitClk <= strobes.sampleNow;
      if (strobes.sampleNow) bitOut <= cmpDecision;
    end
  end

  always_comb begin
    biasCom = 1'b0;
    biasF1  = 1'b1;
    biasF2  = 1'b1;
    thTrack = 1'b1;
    unique case (strobes.phase)
      PH_TRACK: begin
        biasCom = 1'b1;
        biasF1  = 1'b0;
        biasF2  = 1'b0;
      end
      PH_FLIP: thTrack = 1'b0;
      PH_FEEDBACK: begin
        biasF1 = ~bitOut;
        biasF2 = bitOut;
      end
      default: ;
    endcase
  end

  assign cmpStrobe = strobes.sampleNow;

endmodule

// File: rtl/tsd_phase_seq.sv
module tsd_phase_seq
  import tsd_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] trackLen,
  input  logic [CNT_W-1:0] flipLen,
  input  logic [CNT_W-1:0] fbLen,
  input  logic [CNT_W-1:0] padLen,
  input  logic [CNT_W-1:0] periodLen,
  input  logic             cmpDecision,
  output logic             biasCom,
  output logic             biasF1,
  output logic             biasF2,
  output logic             thTrack,
  output logic             cmpStrobe,
  output logic             bitOut,
  output logic             bitClk,
  output logic             cfgError
);

  seqStrobes_t strobes;

  tsd_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trackLen (trackLen),
    .flipLen  (flipLen),
    .fbLen    (fbLen),
    .padLen   (padLen),
    .periodLen(periodLen),
    .strobes  (strobes),
    .cfgError (cfgError)
  );

  tsd_seq_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmpDecision(cmpDecision),
    .biasCom    (biasCom),
    .biasF1     (biasF1),
    .biasF2     (biasF2),
    .thTrack    (thTrack),
    .cmpStrobe  (cmpStrobe),
    .bitOut     (bitOut),
    .bitClk     (bitClk)
  );

endmodule

// File: rtl/tsd_phase_seq_chk.sv
module tsd_phase_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmpDecision,
  input logic biasCom,
  input logic biasF1,
  input logic biasF2,
  input logic thTrack,
  input logic cmpStrobe,
  input logic bitOut,
  input logic bitClk,
  input logic cfgError
);

  p_track_pattern_r2: assert property (@(posedge clk) disable iff (!rstN)
    biasCom |-> (!biasF1 && !biasF2 && thTrack));

  p_strobe_in_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |-> (!thTrack && !biasCom && biasF1 && biasF2));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> !cmpStrobe);

  p_bit_after_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> (bitClk && bitOut == $past(cmpDecision)));

  p_bitclk_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitClk |-> $past(cmpStrobe));

  p_bit_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !bitClk |-> $stable(bitOut));

  p_one_half_cut_r5: assert property (@(posedge clk) disable iff (!rstN)
    (biasF1 != biasF2) |-> (!biasCom && thTrack && biasF2 == bitOut));

  p_never_both_cut_r5: assert property (@(posedge clk) disable iff (!rstN)
    !biasCom |-> (biasF1 || biasF2));

  p_err_at_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgError) |-> (biasCom && !$past(biasCom)));

endmodule

bind tsd_phase_seq tsd_phase_seq_chk u_chk (.*);

// File: tb/test_tsd_phase_seq.sv
module test_tsd_phase_seq;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] trackLen, flipLen, fbLen, padLen, periodLen;
  logic             cmpDecision;
  logic             biasCom, biasF1, biasF2, thTrack;
  logic             cmpStrobe, bitOut, bitClk, cfgError;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tsd_phase_seq #(.CNT_W(CNT_W)) i_tsd_phase_seq (
    .clk(clk), .rstN(rstN),
    .trackLen(trackLen), .flipLen(flipLen), .fbLen(fbLen), .padLen(padLen),
    .periodLen(periodLen), .cmpDecision(cmpDecision),
    .biasCom(biasCom), .biasF1(biasF1), .biasF2(biasF2), .thTrack(thTrack),
    .cmpStrobe(cmpStrobe), .bitOut(bitOut), .bitClk(bitClk), .cfgError(cfgError)
  );

  // 1 track, 2 flip, 3 feedback cutting half one, 4 feedback cutting half two, 5 nominal
  function automatic int cls();
    if (biasCom && !biasF1 && !biasF2 && thTrack) return 1;
    if (!biasCom && biasF1 && biasF2 && !thTrack) return 2;
    if (!biasCom && !biasF1 && biasF2 && thTrack) return 3;
    if (!biasCom && biasF1 && !biasF2 && thTrack) return 4;
    if (!biasCom && biasF1 && biasF2 && thTrack) return 5;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic applyCfg(input int t, input int f, input int fb, input int pd, input int per);
    trackLen  = CNT_W'(t);
    flipLen   = CNT_W'(f);
    fbLen     = CNT_W'(fb);
    padLen    = CNT_W'(pd);
    periodLen = CNT_W'(per);
  endtask

  task automatic syncTrack();
    @(negedge clk);
    while (cls() == 1) @(negedge clk);
    while (cls() != 1) @(negedge clk);
  endtask

  // entered on the first track cycle of a period, left on the first track cycle of the next
  task automatic measure(input int eT, input int eF, input int eFb, input int ePad,
                         input logic dec, input string tag);
    int n;
    int strobes;
    int wrong;
    logic lastStb;
    cmpDecision = dec;
    n = 0;
    while (cls() == 1) begin n++; @(negedge clk); end
    chk(n == eT, {tag, " R2 track length"}, n, eT);
    n = 0; strobes = 0; lastStb = 1'b0;
    while (cls() == 2) begin
      n++;
      strobes += int'(cmpStrobe);
      lastStb = cmpStrobe;
      @(negedge clk);
    end
    chk(n == eF, {tag, " R3 flip length"}, n, eF);
    chk(strobes == 1 && lastStb, {tag, " R3 strobe only on last flip cycle"}, strobes, 1);
    chk(bitClk == 1'b1, {tag, " R4 bitClk after strobe"}, int'(bitClk), 1);
    chk(bitOut == dec, {tag, " R4 bitOut equals decision"}, int'(bitOut), int'(dec));
    n = 0; wrong = 0;
    while (cls() == 3 || cls() == 4) begin
      if (cls() != (dec ? 3 : 4)) wrong++;
      n++;
      @(negedge clk);
    end
    chk(n == eFb, {tag, " R5 feedback length"}, n, eFb);
    chk(wrong == 0, {tag, " R5 half cut by decision"}, wrong, 0);
    n = 0;
    while (cls() == 5) begin n++; @(negedge clk); end
    chk(n == ePad, {tag, " R6 padding length"}, n, ePad);
    chk(cls() == 1, {tag, " R2 order returns to track"}, cls(), 1);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    cmpDecision = 1'b1;
    applyCfg(4, 3, 5, 4, 16);
    repeat (3) @(negedge clk);
    chk(cls() == 5, "R1 nominal bias in reset", cls(), 5);
    chk(!bitOut && !bitClk && !cmpStrobe, "R1 bit outputs low in reset",
        int'({bitOut, bitClk, cmpStrobe}), 0);
    chk(cfgError == 1'b0, "R1 cfgError low in reset", int'(cfgError), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cls() == 1, "R2 first period opens after reset", cls(), 1);
    chk(bitOut == 1'b0 && bitClk == 1'b0, "R1 bitstream low before first strobe",
        int'({bitOut, bitClk}), 0);
  endtask

  task automatic t_basic(input logic dec);
    applyCfg(4, 3, 5, 4, 16);
    syncTrack();
    chk(cfgError == 1'b0, "R7 consistent set clears cfgError", int'(cfgError), 0);
    measure(4, 3, 5, 4, dec, "basic");
  endtask

  task automatic t_skipFb();
    applyCfg(3, 2, 0, 5, 10);
    syncTrack();
    measure(3, 2, 0, 5, 1'b1, "skipFb");
  endtask

  task automatic t_skipPad();
    applyCfg(2, 2, 6, 0, 10);
    syncTrack();
    measure(2, 2, 6, 0, 1'b0, "skipPad");
  endtask

  task automatic t_mismatch();
    applyCfg(3, 2, 2, 2, 20);
    syncTrack();
    chk(cfgError == 1'b1, "R7 sum mismatch raises cfgError", int'(cfgError), 1);
    measure(3, 2, 2, 2, 1'b1, "mismatch");
    applyCfg(0, 0, 3, 1, 4);
    syncTrack();
    chk(cfgError == 1'b1, "R7 zero track and flip raise cfgError", int'(cfgError), 1);
    measure(1, 1, 3, 1, 1'b0, "zeroLen R8");
    applyCfg(2, 3, 1, 2, 8);
    syncTrack();
    chk(cfgError == 1'b0, "R7 cfgError clears on good set", int'(cfgError), 0);
    measure(2, 3, 1, 2, 1'b1, "recover");
  endtask

  task automatic t_midChange();
    applyCfg(5, 2, 3, 6, 16);
    syncTrack();
    applyCfg(2, 4, 7, 1, 14);
    measure(5, 2, 3, 6, 1'b1, "oldSet R9");
    measure(2, 4, 7, 1, 1'b0, "newSet R9");
  endtask

  task automatic t_toggle();
    applyCfg(3, 3, 2, 2, 10);
    syncTrack();
    for (int i = 0; i < 6; i++) measure(3, 3, 2, 2, logic'(i % 2), "toggle R4");
  endtask

  initial begin
    t_reset();
    t_basic(1'b1);
    t_basic(1'b0);
    t_skipFb();
    t_skipPad();
    t_mismatch();
    t_midChange();
    t_toggle();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule